// File: doc/BRIEF.md
# Tagged Reservation Stations with Shared Result Bus

This block is the dispatch core of an out-of-order floating-point engine. Operations arrive in program order at an issue port, one per cycle, from an external operation queue. Each operation is placed in a free station of its class. There are load buffers, add/subtract stations and multiply stations. Every station is named by a 4-bit tag. At issue, a source register is turned into either its value or the tag of the station that will produce it. The destination register is then marked with the new station's tag, which renames it without any separate rename table.

Stations wait for missing operands by watching a single result bus. The bus carries a 64-bit value and the tag of the station that produced it. Any waiting station, or any register whose pending tag equals that tag, takes the value. A station whose operands are both present is handed to its fixed-latency unit: one adder and one multiplier, each holding one operation at a time. Load buffers count down a fixed memory latency on their own. Finished results compete for the bus, one winner per cycle, and the winning station is freed. A read port exposes each register's value and pending tag.

Top module: `rs_cdb_core`

## Requirements
- R1: `iss_ready` is high only when a station of the class named by `iss_op` is free. An issue with `iss_ready` low changes no register tag and produces no broadcast.
- R2: Tag 0 means no producer and a valid value. Load buffers carry tags 1..6, add stations tags 7..9 and multiply stations tags 10..11. The lowest free station of the class is taken, and its tag is shown on `iss_tag`.
- R3: At issue, a source whose register tag is 0 is captured as a value. So is a source whose pending tag is being broadcast in that same cycle, taking the bus data. Any other source is captured as the pending tag.
- R4: At issue, the destination register's tag becomes the new station's tag. This holds even when a broadcast in the same cycle matches the register's old tag.
- R5: A station is handed to its unit only with both operands present. Each unit holds one operation until that result has been broadcast, and the lowest-index ready station goes first.
- R6: Op codes are 0 load (result is `iss_imm`), 1 add, 2 subtract and 3 multiply (low 64 bits of the product). A lone load is broadcast LD_LAT cycles after its issue edge. A lone add with ready operands is broadcast ADD_LAT+1 cycles after it.
- R7: Every waiting station whose operand tag equals the broadcast tag latches the bus data, so dependent chains complete.
- R8: A register whose pending tag equals the broadcast tag takes the data and clears its tag. A register that has since been retagged keeps its newer tag and value.
- R9: One broadcast is made per cycle. Multiply results win over add results, and add results win over loads. Within a class the higher index wins. Losers hold their results for a later cycle.
- R10: The station that broadcasts is free in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Head of the operation queue is present |
| iss_op | input | 2 | Operation code |
| iss_rd | input | 3 | Destination register |
| iss_rs1 | input | 3 | First source register |
| iss_rs2 | input | 3 | Second source register |
| iss_imm | input | 64 | Load value |
| iss_ready | output | 1 | A station of the class is free |
| iss_tag | output | 4 | Tag given to the operation being issued |
| add_go | output | 1 | Dispatch to the add unit |
| add_tag | output | 4 | Station dispatched to the add unit |
| add_sub | output | 1 | Dispatched operation is a subtract |
| add_a | output | 64 | Add unit first operand |
| add_b | output | 64 | Add unit second operand |
| mul_go | output | 1 | Dispatch to the multiply unit |
| mul_tag | output | 4 | Station dispatched to the multiply unit |
| mul_a | output | 64 | Multiply unit first operand |
| mul_b | output | 64 | Multiply unit second operand |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | 4 | Producing station tag |
| cdb_data | output | 64 | Result value |
| rf_addr | input | 3 | Register read address |
| rf_val | output | 64 | Register value |
| rf_tag | output | 4 | Register pending tag |

## Verification
The hardest cases to reach are two results finishing on the same edge, and a register retagged while its older producer is still in flight. The stimulus reaches the first by placing issues a precise number of cycles apart, so that an add and a load, and then a multiply and an add, complete together. Broadcast cycle stamps then show the winner one cycle ahead of the loser. For the second, a slow multiply and a fast add target the same register, with a consumer issued between them, and the final register value must be the add's. A further case issues an operation in the same cycle its source is being broadcast, so the operand must be taken from the bus.

// File: rtl/rs_cdb_core.sv
module rs_cdb_core #(
  parameter int NLD = 6,
  parameter int NADD = 3,
  parameter int NMUL = 2,
  parameter int NREG = 8,
  parameter int W = 64,
  parameter int TW = 4,
  parameter int LD_LAT = 2,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [1:0]              iss_op,
  input  logic [$clog2(NREG)-1:0] iss_rd,
  input  logic [$clog2(NREG)-1:0] iss_rs1,
  input  logic [$clog2(NREG)-1:0] iss_rs2,
  input  logic [W-1:0]            iss_imm,
  output logic                    iss_ready,
  output logic [TW-1:0]           iss_tag,
  output logic                    add_go,
  output logic [TW-1:0]           add_tag,
  output logic                    add_sub,
  output logic [W-1:0]            add_a,
  output logic [W-1:0]            add_b,
  output logic                    mul_go,
  output logic [TW-1:0]           mul_tag,
  output logic [W-1:0]            mul_a,
  output logic [W-1:0]            mul_b,
  output logic                    cdb_valid,
  output logic [TW-1:0]           cdb_tag,
  output logic [W-1:0]            cdb_data,
  input  logic [$clog2(NREG)-1:0] rf_addr,
  output logic [W-1:0]            rf_val,
  output logic [TW-1:0]           rf_tag
);
  localparam int NS = NLD + NADD + NMUL;
  localparam int A0 = NLD;
  localparam int M0 = NLD + NADD;
  localparam logic [1:0] OP_LD = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2, OP_MUL = 2'd3;
  localparam logic [1:0] S_FREE = 2'd0, S_WAIT = 2'd1, S_EXEC = 2'd2, S_DONE = 2'd3;

  logic [1:0]    st   [NS];
  logic [1:0]    sop  [NS];
  logic [TW-1:0] qj   [NS];
  logic [TW-1:0] qk   [NS];
  logic [W-1:0]  vj   [NS];
  logic [W-1:0]  vk   [NS];
  logic [W-1:0]  res  [NS];
  logic [3:0]    cnt  [NS];
  logic [W-1:0]  rval [NREG];
  logic [TW-1:0] rtag [NREG];

  int iss_i, add_i, mul_i, g_i;
  logic iss_fnd, add_fnd, add_busy, mul_fnd, mul_busy, issue;
  logic [TW-1:0] s1_q, s2_q;
  logic [W-1:0]  s1_v, s2_v;

  always_comb begin
    int lo, hi;
    lo = (iss_op == OP_LD) ? 0 : (iss_op == OP_MUL) ? M0 : A0;
    hi = (iss_op == OP_LD) ? A0 : (iss_op == OP_MUL) ? NS : M0;
    iss_fnd = 1'b0;
    iss_i = 0;
    for (int i = NS - 1; i >= 0; i--)
      if (i >= lo && i < hi && st[i] == S_FREE) begin
        iss_fnd = 1'b1;
        iss_i = i;
      end
  end

  assign iss_ready = iss_fnd;
  assign iss_tag   = TW'(iss_i + 1);
  assign issue     = iss_valid && iss_fnd;

  always_comb begin
    add_fnd = 1'b0; add_busy = 1'b0; add_i = A0;
    for (int i = M0 - 1; i >= A0; i--) begin
      if (st[i] == S_EXEC || st[i] == S_DONE) add_busy = 1'b1;
      if (st[i] == S_WAIT && qj[i] == '0 && qk[i] == '0) begin
        add_fnd = 1'b1;
        add_i = i;
      end
    end
    mul_fnd = 1'b0; mul_busy = 1'b0; mul_i = M0;
    for (int i = NS - 1; i >= M0; i--) begin
      if (st[i] == S_EXEC || st[i] == S_DONE) mul_busy = 1'b1;
      if (st[i] == S_WAIT && qj[i] == '0 && qk[i] == '0) begin
        mul_fnd = 1'b1;
        mul_i = i;
      end
    end
  end

  assign add_go  = add_fnd && !add_busy;
  assign add_tag = TW'(add_i + 1);
  assign add_sub = sop[add_i] == OP_SUB;
  assign add_a   = vj[add_i];
  assign add_b   = vk[add_i];
  assign mul_go  = mul_fnd && !mul_busy;
  assign mul_tag = TW'(mul_i + 1);
  assign mul_a   = vj[mul_i];
  assign mul_b   = vk[mul_i];

  always_comb begin
    cdb_valid = 1'b0;
    g_i = 0;
    for (int i = 0; i < NS; i++)
      if (st[i] == S_DONE) begin
        cdb_valid = 1'b1;
        g_i = i;
      end
  end

  assign cdb_tag  = cdb_valid ? TW'(g_i + 1) : '0;
  assign cdb_data = res[g_i];

  always_comb begin
    s1_q = rtag[iss_rs1]; s1_v = rval[iss_rs1];
    if (s1_q != '0) begin
      if (cdb_valid && cdb_tag == s1_q) begin s1_q = '0; s1_v = cdb_data; end
      else s1_v = '0;
    end
    s2_q = rtag[iss_rs2]; s2_v = rval[iss_rs2];
    if (s2_q != '0) begin
      if (cdb_valid && cdb_tag == s2_q) begin s2_q = '0; s2_v = cdb_data; end
      else s2_v = '0;
    end
  end

  assign rf_val = rval[rf_addr];
  assign rf_tag = rtag[rf_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        st[i] <= S_FREE; sop[i] <= OP_LD; qj[i] <= '0; qk[i] <= '0;
        vj[i] <= '0; vk[i] <= '0; res[i] <= '0; cnt[i] <= '0;
      end
      for (int r = 0; r < NREG; r++) begin
        rval[r] <= '0;
        rtag[r] <= '0;
      end
    end else begin
      for (int i = 0; i < NS; i++) begin
        case (st[i])
          S_WAIT: begin
            if (cdb_valid && qj[i] == cdb_tag) begin vj[i] <= cdb_data; qj[i] <= '0; end
            if (cdb_valid && qk[i] == cdb_tag) begin vk[i] <= cdb_data; qk[i] <= '0; end
            if (add_go && add_i == i) begin st[i] <= S_EXEC; cnt[i] <= 4'(ADD_LAT - 1); end
            if (mul_go && mul_i == i) begin st[i] <= S_EXEC; cnt[i] <= 4'(MUL_LAT - 1); end
          end
          S_EXEC: begin
            if (cnt[i] == '0) begin
              st[i] <= S_DONE;
              case (sop[i])
                OP_ADD:  res[i] <= vj[i] + vk[i];
                OP_SUB:  res[i] <= vj[i] - vk[i];
                OP_MUL:  res[i] <= vj[i] * vk[i];
                default: res[i] <= vj[i];
              endcase
            end else cnt[i] <= cnt[i] - 4'd1;
          end
          S_DONE: if (g_i == i) st[i] <= S_FREE;
          default: begin
            if (issue && iss_i == i) begin
              sop[i] <= iss_op;
              if (iss_op == OP_LD) begin
                st[i] <= S_EXEC; cnt[i] <= 4'(LD_LAT - 1);
                vj[i] <= iss_imm; qj[i] <= '0; vk[i] <= '0; qk[i] <= '0;
              end else begin
                st[i] <= S_WAIT;
                vj[i] <= s1_v; qj[i] <= s1_q; vk[i] <= s2_v; qk[i] <= s2_q;
              end
            end
          end
        endcase
      end
      for (int r = 0; r < NREG; r++) begin
        if (cdb_valid && rtag[r] == cdb_tag) begin
          rval[r] <= cdb_data;
          rtag[r] <= '0;
        end
        if (issue && int'(iss_rd) == r) rtag[r] <= iss_tag;
      end
    end
  end

  a_r10_winner_freed: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |=> st[$past(g_i)] == S_FREE);
  a_r1_issue_claims_station: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> st[$past(iss_i)] != S_FREE);
  a_r8_reg_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && rf_tag == cdb_tag && !(iss_valid && iss_ready && iss_rd == rf_addr))
      ##1 $stable(rf_addr) |-> (rf_tag == '0 && rf_val == $past(cdb_data)));
  a_r4_newer_tag_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_rd == rf_addr) ##1 $stable(rf_addr) |-> rf_tag == $past(iss_tag));
  a_r5_add_unit_single: assert property (@(posedge clk) disable iff (!rst_n)
    add_go |=> !add_go);
  a_r5_mul_unit_single: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |=> !mul_go);
  a_r9_bus_tag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> cdb_tag != '0);
endmodule

// File: tb/tb_rs_cdb_core.sv
module tb_rs_cdb_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [1:0] iss_op = 2'd0;
  logic [2:0] iss_rd = '0, iss_rs1 = '0, iss_rs2 = '0, rf_addr = '0;
  logic [63:0] iss_imm = '0;
  logic iss_ready, add_go, add_sub, mul_go, cdb_valid;
  logic [3:0] iss_tag, add_tag, mul_tag, cdb_tag, rf_tag;
  logic [63:0] add_a, add_b, mul_a, mul_b, cdb_data, rf_val;

  rs_cdb_core dut (.*);

  always #10 clk = ~clk;

  typedef struct { logic [3:0] t; logic [63:0] d; } item_t;
  item_t q[$];
  logic [63:0] refv [8];
  int bc_cyc [16];
  int cyc = 0, ntest = 0, nfail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cdb_valid) begin
      int f;
      f = -1;
      for (int k = 0; k < q.size(); k++)
        if (f < 0 && q[k].t == cdb_tag) f = k;
      if (f < 0) chk(1'b0, "R1 unexpected broadcast", 64'(cdb_tag), 64'hff);
      else begin
        chk(cdb_data == q[f].d, "R6 broadcast data", cdb_data, q[f].d);
        bc_cyc[cdb_tag] = cyc;
        q.delete(f);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input int rd, input int a, input int b,
                       input logic [63:0] imm, output int tag, output int icyc);
    logic [63:0] e;
    @(negedge clk);
    iss_op = op; iss_rd = 3'(rd); iss_rs1 = 3'(a); iss_rs2 = 3'(b); iss_imm = imm;
    iss_valid = 1'b1;
    #1;
    while (!iss_ready) begin @(negedge clk); #1; end
    tag = int'(iss_tag);
    case (op)
      2'd0: begin e = imm;               chk(tag >= 1 && tag <= 6,  "R2 load tag", 64'(tag), 1); end
      2'd1: begin e = refv[a] + refv[b]; chk(tag >= 7 && tag <= 9,  "R2 add tag", 64'(tag), 7); end
      2'd2: begin e = refv[a] - refv[b]; chk(tag >= 7 && tag <= 9,  "R2 sub tag", 64'(tag), 7); end
      default: begin e = refv[a] * refv[b]; chk(tag >= 10 && tag <= 11, "R2 mul tag", 64'(tag), 10); end
    endcase
    q.push_back('{t: 4'(tag), d: e});
    refv[rd] = e;
    @(posedge clk);
    #1;
    iss_valid = 1'b0;
    icyc = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drain(input string req);
    repeat (30) @(posedge clk);
    chk(q.size() == 0, req, 64'(q.size()), 0);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      rf_addr = 3'(r);
      #1;
      chk(rf_val == refv[r], "R8 register value", rf_val, refv[r]);
      chk(rf_tag == 4'd0, "R8 tag cleared", 64'(rf_tag), 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    int t1, t2, t3, c1, c2, c3, ta, tl, tm, ca, cl, cm;
    for (int r = 0; r < 8; r++) refv[r] = '0;
    for (int k = 0; k < 16; k++) bc_cyc[k] = -1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(iss_ready == 1'b1, "R2 ready after reset", 64'(iss_ready), 1);
    chk(cdb_valid == 1'b0, "R9 bus idle after reset", 64'(cdb_valid), 0);
    rf_addr = 3'd4;
    #1;
    chk(rf_tag == 4'd0 && rf_val == 64'd0, "R2 reset register", 64'(rf_tag), 0);

    // R3/R7: loads, then dependents issued while loads are pending
    issue(2'd0, 1, 0, 0, 64'd5, t1, c1);
    issue(2'd0, 2, 0, 0, 64'd7, t2, c2);
    issue(2'd0, 3, 0, 0, 64'd100, t3, c3);
    chk(t1 == 1 && t2 == 2 && t3 == 3, "R2 lowest free load", 64'(t3), 3);
    issue(2'd1, 4, 1, 2, 0, ta, ca);
    issue(2'd2, 5, 3, 1, 0, ta, ca);
    issue(2'd3, 6, 4, 2, 0, tm, cm);
    drain("R7 chain complete");
    chk(bc_cyc[t1] == c1 + 2, "R6 load latency", 64'(bc_cyc[t1]), 64'(c1 + 2));

    // R3 same-cycle bypass: consumer issued on the broadcast cycle of its source
    issue(2'd0, 1, 0, 0, 64'd11, t1, c1);
    idle(2);
    issue(2'd1, 7, 1, 1, 0, ta, ca);
    drain("R3 bypass source");

    // R1/R5: structural stall on add stations
    issue(2'd3, 7, 6, 2, 0, tm, cm);
    issue(2'd1, 1, 7, 2, 0, ta, ca);
    issue(2'd1, 3, 7, 1, 0, ta, ca);
    issue(2'd1, 4, 7, 3, 0, ta, ca);
    @(negedge clk);
    iss_op = 2'd1; iss_rd = 3'd5; rf_addr = 3'd5;
    #1;
    chk(iss_ready == 1'b0, "R1 adds full", 64'(iss_ready), 0);
    chk(add_go == 1'b0, "R5 no dispatch without operands", 64'(add_go), 0);
    iss_op = 2'd0;
    #1;
    chk(iss_ready == 1'b1, "R1 load class free", 64'(iss_ready), 1);
    iss_op = 2'd1;
    iss_valid = 1'b1;
    @(posedge clk);
    #1 iss_valid = 1'b0;
    @(negedge clk);
    #1;
    chk(rf_tag == 4'd0, "R1 stalled issue ignored", 64'(rf_tag), 0);
    drain("R1 stall drained");

    // R4/R8: slow producer overtaken by newer writer of same register
    issue(2'd3, 6, 2, 2, 0, tm, cm);
    issue(2'd1, 5, 6, 2, 0, ta, ca);
    issue(2'd1, 6, 2, 2, 0, ta, ca);
    drain("R4 rename ordering");
    chk(refv[6] == 64'd14, "R4 newer value kept", refv[6], 64'd14);

    // R9: add and load complete together; add wins
    issue(2'd1, 1, 2, 2, 0, ta, ca);
    issue(2'd0, 3, 0, 0, 64'd77, tl, cl);
    drain("R9 add vs load");
    chk(bc_cyc[ta] == ca + 3, "R6 add latency", 64'(bc_cyc[ta]), 64'(ca + 3));
    chk(bc_cyc[tl] == bc_cyc[ta] + 1, "R9 load held one cycle", 64'(bc_cyc[tl]), 64'(bc_cyc[ta] + 1));

    // R9: multiply and add complete together; multiply wins
    issue(2'd3, 4, 2, 3, 0, tm, cm);
    idle(1);
    issue(2'd1, 5, 2, 3, 0, ta, ca);
    drain("R9 mul vs add");
    chk(bc_cyc[tm] == cm + 5, "R9 mul first", 64'(bc_cyc[tm]), 64'(cm + 5));
    chk(bc_cyc[ta] == cm + 6, "R9 add held", 64'(bc_cyc[ta]), 64'(cm + 6));

    // R10: freed station reused right after its broadcast
    issue(2'd0, 2, 0, 0, 64'd3, t1, c1);
    chk(t1 == 1, "R10 station reused", 64'(t1), 1);
    drain("R10 reuse drained");

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule